// File: doc/BRIEF.md
# Low-Window Extended Address Mapper

This block widens the 16-bit logical address of an 8-bit CPU to a 24-bit physical memory bus. The logical space is split in two 32 KB halves. The upper half never moves. It always lands on the top 32 KB page of the 512 KB local RAM. The lower half is a movable window whose base comes from a page register. The window can point at local ROM, at local RAM, or at off-board memory anywhere from 1 MB up to 16 MB. When it points off-board, an external-access flag and its inverse steer the bus transceivers. A direction output tells them when data flows back onto the board.

Software loads the page register with two byte-wide I/O writes, one for the low byte of the page number and one for the high part. It can read either byte back through the same I/O ports. A 32 KB page number below 32 stays inside the low megabyte and selects one of the local devices. A region bit in the register chooses ROM or RAM. Reset leaves the window on ROM page 0, so the CPU always boots from ROM.

All mapping outputs are combinational from the CPU address and the register. A register write takes effect on the clock edge that captures it. The control and status pins are plain levels with no handshake.

Top module: `xm_top`

## Requirements
- R1: A memory request with cpu_addr[15]=1 asserts ram_sel only, whatever the page register holds, and drives phys_addr = 0x078000 + cpu_addr[14:0].
- R2: A memory request with cpu_addr[15]=0, a page number below 32 and the region bit set asserts rom_sel only, and drives phys_addr = page*0x8000 + cpu_addr[14:0].
- R3: The same request with the region bit clear asserts ram_sel only, and drives the same phys_addr formula as R2.
- R4: A memory request with cpu_addr[15]=0 and a page number of 32 or more sets xmem=1 and xmem_n=0 with no local select, whatever the region bit holds. phys_addr = page*0x8000 + cpu_addr[14:0], and page 32 gives 0x100000.
- R5: With mreq low, ram_sel, rom_sel and xmem are 0 and xmem_n is 1.
- R6: After reset the page number is 0 and the region bit is 1. A window access then selects ROM at physical address 0, and the two read-back bytes are 0x00 (low port) and 0x80 (high port).
- R7: An I/O write to port 0x78 loads page[7:0]. An I/O write to port 0x79 loads page[8] from data bit 0 and the region bit from data bit 7. Data bits 6..1 on port 0x79 and writes to any other port change nothing. A write is visible from the next clock edge onward.
- R8: With io_rd high, io_rdata returns page[7:0] on port 0x78, returns {region, 6'b0, page[8]} on port 0x79, and returns 0 on any other port or when io_rd is low.
- R9: xbus_inbound is 1 exactly when xmem is 1 and rd_n is 0 (an off-board read); otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Logical CPU address |
| mreq | input | 1 | Memory request, active high |
| rd_n | input | 1 | 0 = read cycle, 1 = write cycle |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read-back data |
| phys_addr | output | 24 | Physical address |
| ram_sel | output | 1 | Local RAM select |
| rom_sel | output | 1 | Local ROM select |
| xmem | output | 1 | Off-board access in progress |
| xmem_n | output | 1 | Complement of xmem |
| xbus_inbound | output | 1 | Bus transceivers drive toward the board |

## Verification
The assertions expect the CPU and I/O inputs to hold known values from the first clock after reset. The one-cycle write check also expects the register to be written only through io_wr, so that the last written low byte shows up in the window address. The bench meets both conditions by driving every input to a defined value from time zero and by changing inputs only on falling edges. Register writes go through a task that raises io_wr for exactly one rising edge. The bench then moves the window and samples mid-cycle, so the combinational outputs have settled against the newly stored value.

// File: rtl/xm_pkg.sv
package xm_pkg;
  // Where the current memory cycle is steered
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2,
    TGT_EXT  = 2'd3
  } xm_tgt_e;
endpackage

// File: rtl/xm_pagereg.sv
module xm_pagereg #(
  parameter int IO_W    = 8,
  parameter int PAGE_W  = 9,
  parameter logic [IO_W-1:0] LO_PORT = 8'h78,
  parameter logic [IO_W-1:0] HI_PORT = 8'h79
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_W-1:0]   io_port,
  input  logic [IO_W-1:0]   io_wdata,
  output logic [PAGE_W-1:0] page_num,
  output logic              rom_bit,
  output logic [IO_W-1:0]   io_rdata
);
  localparam int HI_W = PAGE_W - IO_W;

  logic [IO_W-1:0] hi_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_num <= '0;
      rom_bit  <= 1'b1;
    end else if (io_wr) begin
      if (io_port == LO_PORT) begin
        page_num[IO_W-1:0] <= io_wdata;
      end else if (io_port == HI_PORT) begin
        page_num[PAGE_W-1:IO_W] <= io_wdata[HI_W-1:0];
        rom_bit                 <= io_wdata[IO_W-1];
      end
    end
  end

  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = page_num[PAGE_W-1:IO_W];
    hi_word[IO_W-1]     = rom_bit;
    io_rdata            = '0;
    if (io_rd) begin
      if (io_port == LO_PORT)      io_rdata = page_num[IO_W-1:0];
      else if (io_port == HI_PORT) io_rdata = hi_word;
    end
  end
endmodule

// File: rtl/xm_windec.sv
module xm_windec
  import xm_pkg::*;
#(
  parameter int LA_W        = 16,
  parameter int PA_W        = 24,
  parameter int LOCAL_PAGES = 32,
  parameter int RAM_PAGES   = 16
) (
  input  logic                   mreq,
  input  logic [LA_W-1:0]        la,
  input  logic [PA_W-LA_W:0]     page_num,
  input  logic                   rom_bit,
  output logic [PA_W-1:0]        phys,
  output xm_tgt_e                tgt
);
  localparam int OFF_W  = LA_W - 1;
  localparam int PAGE_W = PA_W - OFF_W;
  localparam logic [PAGE_W-1:0] LOC_LIM  = PAGE_W'(LOCAL_PAGES);
  localparam logic [PAGE_W-1:0] RAM_TOP  = PAGE_W'(RAM_PAGES - 1);

  logic upper;
  logic local_pg;

  assign upper    = la[LA_W-1];
  assign local_pg = (page_num < LOC_LIM);

  always_comb begin
    if (upper) phys = {RAM_TOP,  la[OFF_W-1:0]};
    else       phys = {page_num, la[OFF_W-1:0]};

    tgt = TGT_NONE;
    if (mreq) begin
      if (upper)         tgt = TGT_RAM;
      else if (!local_pg) tgt = TGT_EXT;
      else if (rom_bit)  tgt = TGT_ROM;
      else               tgt = TGT_RAM;
    end
  end
endmodule

// File: rtl/xm_top.sv
module xm_top
  import xm_pkg::*;
#(
  parameter int LA_W        = 16,
  parameter int PA_W        = 24,
  parameter int IO_W        = 8,
  parameter int LOCAL_PAGES = 32,
  parameter int RAM_PAGES   = 16,
  parameter logic [7:0] LO_PORT = 8'h78,
  parameter logic [7:0] HI_PORT = 8'h79
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     cpu_addr,
  input  logic            mreq,
  input  logic            rd_n,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [7:0]      io_port,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic [23:0]     phys_addr,
  output logic            ram_sel,
  output logic            rom_sel,
  output logic            xmem,
  output logic            xmem_n,
  output logic            xbus_inbound
);
  localparam int PAGE_W = PA_W - (LA_W - 1);

  logic [PAGE_W-1:0] page_num;
  logic              rom_bit;
  xm_tgt_e           tgt;

  xm_pagereg #(
    .IO_W(IO_W), .PAGE_W(PAGE_W), .LO_PORT(LO_PORT), .HI_PORT(HI_PORT)
  ) u_preg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_port(io_port), .io_wdata(io_wdata),
    .page_num(page_num), .rom_bit(rom_bit), .io_rdata(io_rdata)
  );

  xm_windec #(
    .LA_W(LA_W), .PA_W(PA_W), .LOCAL_PAGES(LOCAL_PAGES), .RAM_PAGES(RAM_PAGES)
  ) u_dec (
    .mreq(mreq), .la(cpu_addr), .page_num(page_num), .rom_bit(rom_bit),
    .phys(phys_addr), .tgt(tgt)
  );

  assign ram_sel      = (tgt == TGT_RAM);
  assign rom_sel      = (tgt == TGT_ROM);
  assign xmem         = (tgt == TGT_EXT);
  assign xmem_n       = ~xmem;
  assign xbus_inbound = xmem & ~rd_n;
endmodule

// File: rtl/xm_chk.sv
module xm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        mreq,
  input logic        io_wr,
  input logic [7:0]  io_port,
  input logic [7:0]  io_wdata,
  input logic [23:0] phys_addr,
  input logic        ram_sel,
  input logic        rom_sel,
  input logic        xmem,
  input logic        xmem_n
);
  // R1
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && cpu_addr[15]) |-> (ram_sel && !rom_sel && !xmem && phys_addr[23:15] == 9'd15));

  // R4
  ext_no_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmem |-> (!ram_sel && !rom_sel && !xmem_n && phys_addr[23:20] != 4'd0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq |-> (!ram_sel && !rom_sel && !xmem && xmem_n));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel, xmem}));

  // R7
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !cpu_addr[15] && $past(io_wr && io_port == 8'h78 && rst_n))
      |-> (phys_addr[22:15] == $past(io_wdata)));
endmodule

bind xm_top xm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq(mreq),
  .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
  .phys_addr(phys_addr), .ram_sel(ram_sel), .rom_sel(rom_sel),
  .xmem(xmem), .xmem_n(xmem_n)
);

// File: tb/tb_xm_top.sv
module tb_xm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mreq = 1'b0;
  logic        rd_n = 1'b1;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [23:0] phys_addr;
  logic        ram_sel, rom_sel, xmem, xmem_n, xbus_inbound;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side copy of what software has written
  logic [8:0] m_page = '0;
  logic       m_rom  = 1'b1;

  always #5 clk = ~clk;

  xm_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq(mreq), .rd_n(rd_n),
    .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .phys_addr(phys_addr), .ram_sel(ram_sel),
    .rom_sel(rom_sel), .xmem(xmem), .xmem_n(xmem_n), .xbus_inbound(xbus_inbound)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // packs {phys, ram, rom, ext, ext_n, inbound}
  function automatic logic [28:0] model(logic [15:0] a, logic mr, logic rn);
    logic [23:0] p;
    logic r, o, x;
    r = 0; o = 0; x = 0;
    if (a[15]) p = 24'h078000 + {9'd0, a[14:0]};
    else       p = {m_page, a[14:0]};
    if (mr) begin
      if (a[15])            r = 1;
      else if (m_page >= 32) x = 1;
      else if (m_rom)       o = 1;
      else                  r = 1;
    end
    return {p, r, o, x, ~x, x & ~rn};
  endfunction

  task automatic access(string req, logic [15:0] a, logic mr, logic rn);
    @(negedge clk);
    cpu_addr = a; mreq = mr; rd_n = rn;
    #2;
    check(req, {3'd0, phys_addr, ram_sel, rom_sel, xmem, xmem_n, xbus_inbound},
          {3'd0, model(a, mr, rn)});
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_port = port; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
    if (port == 8'h78) m_page[7:0] = d;
    if (port == 8'h79) begin m_page[8] = d[0]; m_rom = d[7]; end
  endtask

  task automatic set_page(logic [8:0] p, logic rom);
    io_write(8'h78, p[7:0]);
    io_write(8'h79, {rom, 6'b0, p[8]});
  endtask

  task automatic readback(string req, logic rd, logic [7:0] port, logic [7:0] exp);
    @(negedge clk);
    io_rd = rd; io_port = port;
    #2;
    check(req, {24'd0, io_rdata}, {24'd0, exp});
    io_rd = 0;
  endtask

  task automatic t_reset;
    // R6: boot mapping is ROM page 0
    access("R6 window after reset", 16'h0123, 1, 0);
    check("R6 phys at boot", {8'd0, phys_addr}, 32'h000123);
    readback("R6 lo byte", 1, 8'h78, 8'h00);
    readback("R6 hi byte", 1, 8'h79, 8'h80);
  endtask

  task automatic t_upper;
    set_page(9'd200, 0);
    access("R1 upper read", 16'h8000, 1, 0);
    access("R1 upper top", 16'hFFFF, 1, 1);
    check("R1 top phys", {8'd0, phys_addr}, 32'h07FFFF);
  endtask

  task automatic t_rom;
    set_page(9'd5, 1);
    access("R2 rom page 5", 16'h1234, 1, 0);
    set_page(9'd31, 1);
    access("R2 rom page 31", 16'h7FFF, 1, 0);
    check("R2 page 31 phys", {8'd0, phys_addr}, 32'h0FFFFF);
  endtask

  task automatic t_ram;
    set_page(9'd3, 0);
    access("R3 ram page 3", 16'h0042, 1, 1);
    set_page(9'd31, 0);
    access("R3 ram page 31", 16'h4000, 1, 0);
  endtask

  task automatic t_ext;
    set_page(9'd32, 1);
    access("R4 page 32 read", 16'h0000, 1, 0);
    check("R4 page 32 phys", {8'd0, phys_addr}, 32'h100000);
    access("R4 page 32 write", 16'h0010, 1, 1);
    set_page(9'd511, 0);
    access("R4 page 511", 16'h7FFF, 1, 0);
    check("R4 page 511 phys", {8'd0, phys_addr}, 32'hFFFFFF);
  endtask

  task automatic t_idle;
    set_page(9'd40, 0);
    access("R5 idle window", 16'h0100, 0, 0);
    access("R5 idle upper", 16'h9000, 0, 1);
  endtask

  task automatic t_dir;
    set_page(9'd77, 0);
    access("R9 ext read inbound", 16'h2000, 1, 0);
    check("R9 inbound high", {31'd0, xbus_inbound}, 32'd1);
    access("R9 ext write", 16'h2000, 1, 1);
    check("R9 inbound low", {31'd0, xbus_inbound}, 32'd0);
    access("R9 local read", 16'hA000, 1, 0);
  endtask

  task automatic t_ignored;
    set_page(9'd6, 0);
    io_write(8'h7A, 8'hFF);   // foreign port, R7: no effect
    readback("R7 foreign lo", 1, 8'h78, 8'h06);
    readback("R7 foreign hi", 1, 8'h79, 8'h00);
    access("R7 map after foreign", 16'h0001, 1, 0);
    io_write(8'h79, 8'h7E);   // only bits 0 and 7 count
    readback("R7 hi mask", 1, 8'h79, 8'h00);
    io_write(8'h79, 8'h81);
    readback("R7 hi set", 1, 8'h79, 8'h81);
    access("R7 page 262 ext", 16'h0003, 1, 0);
  endtask

  task automatic t_readback;
    set_page(9'h1A5, 1);
    readback("R8 lo", 1, 8'h78, 8'hA5);
    readback("R8 hi", 1, 8'h79, 8'h81);
    readback("R8 other port", 1, 8'h10, 8'h00);
    readback("R8 no strobe", 0, 8'h78, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_upper();
    t_rom();
    t_ram();
    t_ext();
    t_idle();
    t_dir();
    t_ignored();
    t_readback();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule